// File: doc/BRIEF.md
# Parallel polynomial-permutation bit interleaver

This block reorders the soft bit reliabilities that two constituent soft decoders pass to each other. It holds one frame of N reliabilities in M storage banks, one bank for each bit of a code symbol. A whole symbol of M values goes in per clock, and M permuted values come out per clock. The permutation is p(i) = (F1·i + F2·i²) mod N. No address table is stored. The addresses come from M lane generators, and each generator steps its position by a running first difference. Every update is an addition followed by a conditional subtraction, so no multiplier or divider is needed.

A frame begins with a start pulse, and the direction is chosen in that same cycle. The frame is then written as N/M symbols through a valid-only write port. A done flag rises, and the frame is read as N/M symbols through a ready/valid port.

For the read or write to be free of bank conflicts, the parameters must meet three conditions:
- M is a power of two and N is a multiple of M.
- F1 is odd.
- F2 is a multiple of M.

Under these conditions the M lanes of any symbol always fall in M different banks. For a power-of-two N, the same conditions make p a permutation.

Top module: `polyperm_ilv`

## Requirements
- R1: After reset, rd_valid and wr_done are 0, and no write is accepted until a start pulse.
- R2: After start, one symbol is accepted on each cycle with wr_valid high. wr_done rises on the clock that accepts the N/M-th symbol. Writes that arrive while wr_done is 1 are not stored.
- R3: rd_valid is never 1 while wr_done is 0, so no read begins before the whole frame is written.
- R4: Lane k of a symbol occupies bits [k*W +: W]. Symbol s lane k holds natural position i = s*M+k. With mode 0 (interleave), read beat s lane k equals the written value at position p(s*M+k).
- R5: With mode 1 (deinterleave), the read value at position p(i) equals the written value at position i.
- R6: Interleaving a frame and then deinterleaving the result returns the original frame.
- R7: While rd_valid is 1 and rd_ready is 0, rd_valid stays 1 and rd_data stays unchanged on the next cycle.
- R8: Exactly N/M read beats are delivered per frame. After that, rd_valid stays 0.
- R9: mode is sampled only in the start cycle. Changes to mode later in the frame have no effect.
- R10: A start pulse at any point abandons the current frame. It clears rd_valid and wr_done on the next cycle, and the next frame behaves as a fresh one.
- R11: On every write or read cycle, the M lanes address M distinct banks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Frame start pulse; also samples mode |
| mode | input | 1 | 0 = interleave, 1 = deinterleave |
| wr_valid | input | 1 | A write symbol is present |
| wr_data | input | M*W | M soft values, lane k at [k*W +: W] |
| wr_done | output | 1 | The whole frame has been written |
| rd_ready | input | 1 | The consumer takes the read symbol |
| rd_valid | output | 1 | A read symbol is present |
| rd_data | output | M*W | M permuted soft values, lane k at [k*W +: W] |

## Verification
The block can see a write request and a read issue in the same cycle. To provoke this, the bench holds wr_valid high with a garbage pattern through a whole interleave read. Every read beat must still match the permuted original frame. The bench also restarts a frame while a read symbol is pending, then checks that the valid and done flags drop together and that the next frame is correct.

// File: rtl/polyperm_ilv.sv
module polyperm_ilv #(
  parameter int N  = 64,
  parameter int M  = 4,
  parameter int W  = 8,
  parameter int F1 = 7,
  parameter int F2 = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         mode,
  input  logic         wr_valid,
  input  logic [M*W-1:0] wr_data,
  output logic         wr_done,
  input  logic         rd_ready,
  output logic         rd_valid,
  output logic [M*W-1:0] rd_data
);
  localparam int S  = N / M;
  localparam int LM = $clog2(M);
  localparam int AW = $clog2(N);
  localparam int RW = $clog2(S);
  localparam logic [AW:0] NN = (AW+1)'(N);
  localparam logic [AW-1:0] DG = AW'((2 * F2 * M * M) % N);

  function automatic logic [AW-1:0] madd(input logic [AW-1:0] a, input logic [AW-1:0] b);
    logic [AW:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= NN) s = s - NN;
    return s[AW-1:0];
  endfunction

  function automatic int seed_p(input int k);
    return (F1 * k + F2 * k * k) % N;
  endfunction

  function automatic int seed_g(input int k);
    return (F1 * M + F2 * M * M + 2 * F2 * M * k) % N;
  endfunction

  typedef enum logic [1:0] {IDLE, WRT, RDG, FIN} ph_t;
  ph_t ph;
  logic mode_q;
  logic [RW-1:0] cnt;
  logic last, wr_acc, rd_iss, adv, load, perm;

  assign last    = (cnt == RW'(S - 1));
  assign wr_acc  = wr_valid && (ph == WRT) && !start;
  assign rd_iss  = (ph == RDG) && (rd_ready || !rd_valid) && !start;
  assign adv     = wr_acc || rd_iss;
  assign load    = start || (wr_acc && last);
  assign perm    = (ph == WRT) ? mode_q : !mode_q;
  assign wr_done = ph[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= IDLE;
      cnt      <= '0;
      mode_q   <= 1'b0;
      rd_valid <= 1'b0;
    end else if (start) begin
      ph       <= WRT;
      cnt      <= '0;
      mode_q   <= mode;
      rd_valid <= 1'b0;
    end else begin
      if (adv) cnt <= last ? '0 : cnt + 1'b1;
      if (wr_acc && last) ph <= RDG;
      if (rd_iss && last) ph <= FIN;
      rd_valid <= rd_iss || (rd_valid && !rd_ready);
    end
  end

  logic [M-1:0][AW-1:0] p, g;
  logic [M-1:0][LM-1:0] lbank;
  logic [M-1:0][RW-1:0] lrow;

  for (genvar k = 0; k < M; k++) begin : g_lane
    localparam logic [AW-1:0] P0 = AW'(seed_p(k));
    localparam logic [AW-1:0] G0 = AW'(seed_g(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        p[k] <= P0;
        g[k] <= G0;
      end else if (load) begin
        p[k] <= P0;
        g[k] <= G0;
      end else if (adv) begin
        p[k] <= madd(p[k], g[k]);
        g[k] <= madd(g[k], DG);
      end
    end
    assign lbank[k] = perm ? p[k][LM-1:0] : LM'(k);
    assign lrow[k]  = perm ? RW'(p[k] >> LM) : cnt;
  end

  logic [W-1:0] mem [M][S];
  logic [M-1:0][RW-1:0] brow;
  logic [M-1:0][W-1:0]  bdat, q;
  logic [M-1:0][LM-1:0] sel_q;

  always_comb begin
    brow = '0;
    bdat = '0;
    for (int b = 0; b < M; b++)
      for (int k = 0; k < M; k++)
        if (lbank[k] == LM'(b)) begin
          brow[b] = lrow[k];
          bdat[b] = wr_data[k*W +: W];
        end
  end

  always_ff @(posedge clk) begin
    for (int b = 0; b < M; b++) begin
      if (wr_acc) mem[b][brow[b]] <= bdat[b];
      if (rd_iss) q[b] <= mem[b][brow[b]];
    end
    if (rd_iss) sel_q <= lbank;
  end

  for (genvar k = 0; k < M; k++) begin : g_out
    assign rd_data[k*W +: W] = q[sel_q[k]];
  end
endmodule

// File: rtl/polyperm_ilv_chk.sv
module polyperm_ilv_chk #(
  parameter int N = 64,
  parameter int M = 4,
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           wr_done,
  input logic           rd_ready,
  input logic           rd_valid,
  input logic [M*W-1:0] rd_data,
  input logic           wr_acc,
  input logic           adv,
  input logic [M*$clog2(M)-1:0] lbank
);
  localparam int S  = N / M;
  localparam int LM = $clog2(M);
  localparam int CW = $clog2(S) + 2;

  logic [CW-1:0] cw, cr;
  logic [M-1:0] mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cw <= '0;
      cr <= '0;
    end else if (start) begin
      cw <= '0;
      cr <= '0;
    end else begin
      if (wr_acc) cw <= cw + 1'b1;
      if (rd_valid && rd_ready) cr <= cr + 1'b1;
    end
  end

  always_comb begin
    mask = '0;
    for (int k = 0; k < M; k++) mask[lbank[k*LM +: LM]] = 1'b1;
  end

  assert_no_early_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> wr_done);
  assert_done_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_done) |-> (cw == CW'(S)));
  assert_no_write_after_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc |-> !wr_done);
  assert_hold_when_stalled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !start) |=> (rd_valid && $stable(rd_data)));
  assert_beat_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cr <= CW'(S));
  assert_banks_distinct_R11: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> (mask == {M{1'b1}}));
endmodule

bind polyperm_ilv polyperm_ilv_chk #(.N(N), .M(M), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .wr_done(wr_done),
  .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data),
  .wr_acc(wr_acc), .adv(adv), .lbank(lbank)
);

// File: tb/sim_polyperm_ilv.sv
module sim_polyperm_ilv;
  localparam int CLK_PERIOD = 10;
  localparam int N = 64, M = 4, W = 8, F1 = 7, F2 = 4;
  localparam int S = N / M;

  logic clk = 0, rst_n = 0, start = 0, mode = 0, wr_valid = 0, rd_ready = 0;
  logic [M*W-1:0] wr_data = '0;
  logic wr_done, rd_valid;
  logic [M*W-1:0] rd_data;

  polyperm_ilv #(.N(N), .M(M), .W(W), .F1(F1), .F2(F2)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .wr_valid(wr_valid),
    .wr_data(wr_data), .wr_done(wr_done), .rd_ready(rd_ready),
    .rd_valid(rd_valid), .rd_data(rd_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  int xin[N], yv[N], din[N], dout[N];

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic int pi(input int i);
    return (F1 * i + F2 * i * i) % N;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_start(input logic m);
    @(negedge clk); start = 1; mode = m;
    @(negedge clk); start = 0;
  endtask

  task automatic wr_frame(input bit flip);
    for (int s = 0; s < S; s++) begin
      @(negedge clk);
      chk(rd_valid == 0, "R3 no read during write", rd_valid, 0);
      if (s == S - 1) chk(wr_done == 0, "R2 done before last write", wr_done, 0);
      if (flip) mode = s[0];
      wr_valid = 1;
      for (int k = 0; k < M; k++) wr_data[k*W +: W] = W'(din[s*M+k]);
    end
    @(negedge clk);
    wr_valid = 0;
    chk(wr_done == 1, "R2 done after N/M writes", wr_done, 1);
  endtask

  task automatic rd_frame(input bit stall, input bit garbage, input bit flip);
    int beats = 0, n = 0;
    bit pend = 0;
    logic [M*W-1:0] held = '0;
    while (beats < S && n < 8*S + 40) begin
      @(negedge clk);
      n++;
      if (pend) begin
        chk(rd_valid == 1, "R7 valid held", rd_valid, 1);
        chk(rd_data == held, "R7 data held", int'(rd_data[W-1:0]), int'(held[W-1:0]));
      end
      rd_ready = stall ? ((n % 3) != 1) : 1'b1;
      wr_valid = garbage;
      wr_data = {M{8'hA5}};
      if (flip) mode = n[0];
      pend = rd_valid && !rd_ready;
      held = rd_data;
      if (rd_valid && rd_ready) begin
        for (int k = 0; k < M; k++) dout[beats*M+k] = int'(rd_data[k*W +: W]);
        beats++;
      end
    end
    chk(beats == S, "R8 beat count", beats, S);
    wr_valid = 0; rd_ready = 1;
    for (int t = 0; t < 4; t++) begin
      @(negedge clk);
      chk(rd_valid == 0, "R8 no extra beat", rd_valid, 0);
    end
  endtask

  task automatic chk_int(input string tag);
    for (int i = 0; i < N; i++) chk(dout[i] == din[pi(i)], tag, dout[i], din[pi(i)]);
  endtask

  task automatic chk_deint(input string tag);
    for (int i = 0; i < N; i++) chk(dout[pi(i)] == din[i], tag, dout[pi(i)], din[i]);
  endtask

  initial begin
    for (int i = 0; i < N; i++) xin[i] = (i * 37 + 11) & 255;
    repeat (3) @(negedge clk);
    chk(rd_valid == 0, "R1 reset rd_valid", rd_valid, 0);
    chk(wr_done == 0, "R1 reset wr_done", wr_done, 0);
    rst_n = 1;
    @(negedge clk); wr_valid = 1;
    repeat (S + 2) @(negedge clk);
    chk(wr_done == 0, "R1 writes before start ignored", wr_done, 0);
    wr_valid = 0;

    // R4 interleave, with writes pending during every read cycle (R2)
    din = xin;
    do_start(0); wr_frame(0); rd_frame(0, 1, 0);
    chk_int("R4 interleave");
    yv = dout;

    // R5 / R6 deinterleave with back-pressure
    din = yv;
    do_start(1); wr_frame(0); rd_frame(1, 0, 0);
    chk_deint("R5 deinterleave");
    for (int i = 0; i < N; i++) chk(dout[i] == xin[i], "R6 round trip", dout[i], xin[i]);

    // R9 mode toggled after start
    din = xin;
    do_start(0); wr_frame(1); rd_frame(1, 0, 1);
    chk_int("R9 mode ignored after start");

    // R10 restart part way through a write
    din = yv;
    do_start(1);
    for (int s = 0; s < S/2; s++) begin
      @(negedge clk); wr_valid = 1; wr_data = {M{8'h3C}};
    end
    @(negedge clk); wr_valid = 0;
    din = xin;
    do_start(0); wr_frame(0); rd_frame(0, 0, 0);
    chk_int("R10 restart during write");

    // R10 restart while a read symbol is pending
    din = xin;
    do_start(0); wr_frame(0);
    rd_ready = 0;
    for (int t = 0; t < 10 && !rd_valid; t++) @(negedge clk);
    chk(rd_valid == 1, "R10 read pending", rd_valid, 1);
    do_start(1);
    chk(rd_valid == 0, "R10 restart clears valid", rd_valid, 0);
    chk(wr_done == 0, "R10 restart clears done", wr_done, 0);
    din = yv;
    wr_frame(0); rd_frame(0, 0, 0);
    for (int i = 0; i < N; i++) chk(dout[i] == xin[i], "R10 R6 after restart", dout[i], xin[i]);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule